// File: doc/BRIEF.md
# I2C 10-bit Address Slave Receiver

This block is an I2C slave that only receives and answers to a 10-bit address. It watches the SCL and SDA lines through two-stage synchronisers. It detects start and stop conditions, checks the two address bytes and acknowledges them. It then receives data bytes, acknowledges each one and hands it to a host over a small register interface. The block pulls SDA low to acknowledge and pulls SCL low to stretch the clock. Both drive pins are open-drain enables, where 1 means the line is pulled low.

A single 8-bit compare register serves both address phases. The host loads the high-address pattern (binary 11110, then address bits 9:8, then a 0 for write) before the transfer starts. After the high byte matches, the block holds SCL low until the host writes the low address. After the low byte matches, it holds SCL again until the host writes the high pattern back. An update-address flag tells the host when such a reload is due. When clock stretching is enabled, each data byte clears the clock-hold bit `ckp` and holds SCL low until the host sets the bit again.

The controller is a state machine with twelve states:
- `ST_IDLE`: waits for a start condition.
- `ST_ADDR_HI`: shifts in the high address byte. It goes to `ST_ACK_HI` on a match and to `ST_IGNORE` otherwise.
- `ST_ACK_HI`: drives the ACK and goes to `ST_HOLD_HI` on the 9th SCL fall.
- `ST_HOLD_HI`: holds SCL low. A compare write moves it to `ST_ADDR_LO`.
- `ST_ADDR_LO`: shifts in the low address byte. It goes to `ST_ACK_LO` on a match and to `ST_NACK_LO` otherwise.
- `ST_ACK_LO`: drives the ACK and goes to `ST_HOLD_LO` on the 9th fall.
- `ST_NACK_LO`: leaves SDA released and goes to `ST_IGNORE` on the 9th fall.
- `ST_HOLD_LO`: holds SCL low. A compare write moves it to `ST_DATA`.
- `ST_DATA`: shifts in a data byte and then goes to `ST_ACK_DATA`.
- `ST_ACK_DATA`: drives the ACK. On the 9th fall it goes to `ST_HOLD_DATA` if stretching is enabled and to `ST_DATA` otherwise.
- `ST_HOLD_DATA`: holds SCL low. Setting `ckp` moves it to `ST_DATA`.
- `ST_IGNORE`: sits out the rest of the transfer.

A stop condition in any state goes to `ST_IDLE`. A start condition in any state goes to `ST_ADDR_HI`.

Top module: `i2c10_slave_rx`

## Requirements
- R1: After reset, all flags and `cmp_rdata` are 0, `ckp` is 1, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: A start condition (SDA falling while SCL is high) sets `start_flag`. It also sets `irq_flag` when `cfg_start_ie` is 1. A stop condition (SDA rising while SCL is high) clears `start_flag` and returns the block to idle.
- R3: When the first byte after a start equals `cmp_rdata`, the block pulls SDA low during the 9th SCL pulse. On the 9th SCL fall it sets `ua_flag` and `irq_flag`.
- R4: After a matched address byte, `scl_oe` stays asserted until the host writes the compare register. That write clears `ua_flag` and releases SCL.
- R5: A compare-register write made while an acknowledge (or its NACK slot) is in progress is ignored, and `cmp_rdata` keeps its old value.
- R6: When the second byte equals the reloaded compare value, the block acknowledges it, sets `ua_flag` and `irq_flag`, and holds SCL until the next compare write.
- R7: When the second byte does not match, SDA stays released during the 9th pulse. `ua_flag` and `irq_flag` are still set, `bf_flag` stays 0 and `ckp` is unchanged. SCL is not held, and later bytes are not acknowledged until the next start.
- R8: Each data byte after the two address bytes is acknowledged on the 9th pulse. On the 9th fall it appears on `rx_data` (MSB received first) and sets `bf_flag` and `irq_flag`.
- R9: With `cfg_stretch_en` set to 1, each data byte clears `ckp` and holds SCL low until `ckp_set` sets `ckp` to 1 again.
- R10: A `buf_rd` pulse clears `bf_flag`.
- R11: When the first byte does not equal the compare value (for example, the same pattern with the R/W bit set to 1), the block does not acknowledge it, sets no flag and ignores the rest of the transfer.
- R12: With `cfg_stretch_en` set to 0, data bytes neither hold SCL nor change `ckp`.
- R13: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| cfg_start_ie | input | 1 | Raise the interrupt flag on a start condition |
| cfg_stretch_en | input | 1 | Stretch the clock after each data byte |
| cmp_wr | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | 8 | Value to write into the compare register |
| cmp_rdata | output | 8 | Current compare register value |
| buf_rd | input | 1 | Host read of the receive buffer; clears `bf_flag` |
| rx_data | output | 8 | Last received data byte |
| irq_clr | input | 1 | Clears `irq_flag` |
| ckp_set | input | 1 | Sets the clock-hold release bit `ckp` |
| start_flag | output | 1 | Start seen, cleared by stop |
| ua_flag | output | 1 | Compare register must be reloaded |
| bf_flag | output | 1 | Receive buffer full |
| irq_flag | output | 1 | Interrupt flag |
| ckp | output | 1 | Clock-hold bit (0 = hold SCL after a data byte) |

## Verification
The hardest case to reach is a compare write that lands inside the acknowledge slot. The write has to arrive after the 8th SCL fall has been seen through the synchronisers but before the 9th fall. The bench's byte task can issue a host write while its 9th SCL pulse is high. The bench then checks that `cmp_rdata` is unchanged and that SCL stays held.

The low-address mismatch needs a complete, correctly matched high phase and a reload before the wrong low byte can be sent. The bench then sends one more byte to show that the block ignores it.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ACK_HI,
        ST_HOLD_HI,
        ST_ADDR_LO,
        ST_ACK_LO,
        ST_NACK_LO,
        ST_HOLD_LO,
        ST_DATA,
        ST_ACK_DATA,
        ST_HOLD_DATA,
        ST_IGNORE
    } rx_state_t;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[g] <= {WIDTH{RST_VAL}};
                end else if (g == 0) begin
                    pipe[g] <= din;
                end else begin
                    pipe[g] <= pipe[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c10_bus_events.sv
module i2c10_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        start_evt = scl_s && scl_d && sda_d && !sda_s;
        stop_evt  = scl_s && scl_d && !sda_d && sda_s;
        scl_rise  = scl_s && !scl_d;
        scl_fall  = !scl_s && scl_d;
    end
endmodule

// File: rtl/i2c10_shift.sv
module i2c10_shift #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              scl_rise,
    input  logic              sda_s,
    output logic [BYTE_W-1:0] byte_q,
    output logic              full
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            byte_q <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && scl_rise && !full) begin
            cnt    <= cnt + 1'b1;
            byte_q <= {byte_q[BYTE_W-2:0], sda_s};
        end
    end

    assign full = (cnt == CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              cfg_start_ie,
    input  logic              cfg_stretch_en,
    input  logic              cmp_wr,
    input  logic [BYTE_W-1:0] cmp_wdata,
    output logic [BYTE_W-1:0] cmp_rdata,
    input  logic              buf_rd,
    output logic [BYTE_W-1:0] rx_data,
    input  logic              irq_clr,
    input  logic              ckp_set,
    output logic              start_flag,
    output logic              ua_flag,
    output logic              bf_flag,
    output logic              irq_flag,
    output logic              ckp
);
    import i2c10_pkg::*;

    rx_state_t state, state_nx;

    logic [1:0]        bus_s;
    logic              scl_s, sda_s;
    logic              start_evt, stop_evt, scl_rise, scl_fall;
    logic [BYTE_W-1:0] byte_q;
    logic              byte_full;
    logic              shift_en, shift_clr;
    logic              in_ack, ack_done, addr_done, data_done;
    logic              cmp_accept, addr_match;
    logic [BYTE_W-1:0] cmp_q, rx_q;

    i2c10_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    i2c10_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c10_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (shift_clr),
        .en      (shift_en),
        .scl_rise(scl_rise),
        .sda_s   (sda_s),
        .byte_q  (byte_q),
        .full    (byte_full)
    );

    assign addr_match = (byte_q == cmp_q);
    assign in_ack     = (state == ST_ACK_HI) || (state == ST_ACK_LO) ||
                        (state == ST_NACK_LO) || (state == ST_ACK_DATA);
    assign ack_done   = in_ack && scl_fall;
    assign data_done  = ack_done && (state == ST_ACK_DATA);
    assign addr_done  = ack_done && (state != ST_ACK_DATA);
    assign cmp_accept = cmp_wr && !in_ack;
    assign shift_en   = (state == ST_ADDR_HI) || (state == ST_ADDR_LO) || (state == ST_DATA);
    assign shift_clr  = (state_nx != state);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop_evt) begin
            state_nx = ST_IDLE;
        end else if (start_evt) begin
            state_nx = ST_ADDR_HI;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR_HI:   if (scl_fall && byte_full) state_nx = addr_match ? ST_ACK_HI : ST_IGNORE;
                ST_ACK_HI:    if (scl_fall) state_nx = ST_HOLD_HI;
                ST_HOLD_HI:   if (cmp_accept) state_nx = ST_ADDR_LO;
                ST_ADDR_LO:   if (scl_fall && byte_full) state_nx = addr_match ? ST_ACK_LO : ST_NACK_LO;
                ST_ACK_LO:    if (scl_fall) state_nx = ST_HOLD_LO;
                ST_NACK_LO:   if (scl_fall) state_nx = ST_IGNORE;
                ST_HOLD_LO:   if (cmp_accept) state_nx = ST_DATA;
                ST_DATA:      if (scl_fall && byte_full) state_nx = ST_ACK_DATA;
                ST_ACK_DATA:  if (scl_fall) state_nx = cfg_stretch_en ? ST_HOLD_DATA : ST_DATA;
                ST_HOLD_DATA: if (ckp_set) state_nx = ST_DATA;
                ST_IGNORE:    state_nx = ST_IGNORE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // pin outputs
    always_comb begin
        sda_oe = 1'b0;
        scl_oe = 1'b0;
        unique case (state)
            ST_ACK_HI, ST_ACK_LO, ST_ACK_DATA:    sda_oe = 1'b1;
            ST_HOLD_HI, ST_HOLD_LO, ST_HOLD_DATA: scl_oe = 1'b1;
            default: ;
        endcase
    end

    // host-visible registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q      <= '0;
            rx_q       <= '0;
            start_flag <= 1'b0;
            ua_flag    <= 1'b0;
            bf_flag    <= 1'b0;
            irq_flag   <= 1'b0;
            ckp        <= 1'b1;
        end else begin
            if (cmp_accept) cmp_q <= cmp_wdata;

            if (start_evt)     start_flag <= 1'b1;
            else if (stop_evt) start_flag <= 1'b0;

            if (addr_done)       ua_flag <= 1'b1;
            else if (cmp_accept) ua_flag <= 1'b0;

            if (ack_done || (start_evt && cfg_start_ie)) irq_flag <= 1'b1;
            else if (irq_clr)                           irq_flag <= 1'b0;

            if (data_done) begin
                rx_q    <= byte_q;
                bf_flag <= 1'b1;
            end else if (buf_rd) begin
                bf_flag <= 1'b0;
            end

            if (data_done && cfg_stretch_en) ckp <= 1'b0;
            else if (ckp_set)                ckp <= 1'b1;
        end
    end

    assign cmp_rdata = cmp_q;
    assign rx_data   = rx_q;
endmodule

// File: rtl/i2c10_slave_rx_chk.sv
module i2c10_slave_rx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              scl_oe,
    input logic              ua_flag,
    input logic              ckp,
    input logic              bf_flag,
    input logic              buf_rd,
    input logic              data_done,
    input logic              start_evt,
    input logic              cfg_start_ie,
    input logic              irq_flag,
    input logic              start_flag,
    input logic              cmp_wr,
    input logic              in_ack,
    input logic [BYTE_W-1:0] cmp_rdata,
    input logic              ckp_set
);
    assert_sda_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    assert_hold_reason_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> (ua_flag || !ckp));

    assert_ack_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && cmp_wr) |=> $stable(cmp_rdata));

    assert_start_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && cfg_start_ie) |=> (irq_flag && start_flag));

    assert_buf_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !data_done) |=> !bf_flag);

    assert_ckp_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ckp) |-> $past(ckp_set));
endmodule

bind i2c10_slave_rx i2c10_slave_rx_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe      (sda_oe),
    .scl_oe      (scl_oe),
    .ua_flag     (ua_flag),
    .ckp         (ckp),
    .bf_flag     (bf_flag),
    .buf_rd      (buf_rd),
    .data_done   (data_done),
    .start_evt   (start_evt),
    .cfg_start_ie(cfg_start_ie),
    .irq_flag    (irq_flag),
    .start_flag  (start_flag),
    .cmp_wr      (cmp_wr),
    .in_ack      (in_ack),
    .cmp_rdata   (cmp_rdata),
    .ckp_set     (ckp_set)
);

// File: tb/tb_i2c10_slave_rx.sv
`timescale 1ns/1ps
module tb_i2c10_slave_rx;
    localparam int HALF = 20;
    localparam logic [7:0] HI_ADDR = 8'hF2;
    localparam logic [7:0] LO_ADDR = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe;
    logic cfg_start_ie = 1'b0, cfg_stretch_en = 1'b0;
    logic cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic [7:0] cmp_rdata, rx_data;
    logic buf_rd = 1'b0, irq_clr = 1'b0, ckp_set = 1'b0;
    logic start_flag, ua_flag, bf_flag, irq_flag, ckp;
    logic scl_bus, sda_bus;

    int tests = 0;
    int fails = 0;
    bit ack_seen;

    always #10 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c10_slave_rx dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .cfg_start_ie(cfg_start_ie), .cfg_stretch_en(cfg_stretch_en),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata),
        .buf_rd(buf_rd), .rx_data(rx_data), .irq_clr(irq_clr), .ckp_set(ckp_set),
        .start_flag(start_flag), .ua_flag(ua_flag), .bf_flag(bf_flag),
        .irq_flag(irq_flag), .ckp(ckp)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        cmp_wdata = v; cmp_wr = 1'b1;
        wait_n(1);
        cmp_wr = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1'b1; wait_n(1); irq_clr = 1'b0;
    endtask

    task automatic scl_high_wait();
        scl_m = 1'b1;
        wait (scl_bus === 1'b1);
        @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_n(HALF);
        sda_m = 1'b0; wait_n(HALF);
        scl_m = 1'b0; wait_n(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_n(HALF);
        scl_high_wait(); wait_n(HALF);
        sda_m = 1'b1; wait_n(HALF);
    endtask

    // sends one byte MSB first plus the 9th clock; optionally writes the compare register mid-ACK
    task automatic send_byte(input logic [7:0] b, input bit mid_wr, input logic [7:0] mid_val);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(HALF);
            scl_high_wait(); wait_n(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_n(HALF);
        scl_high_wait(); wait_n(HALF/2);
        ack_seen = (sda_bus === 1'b0);
        if (mid_wr) host_write(mid_val);
        wait_n(HALF/2);
        scl_m = 1'b0; wait_n(HALF);
    endtask

    task automatic t_reset();
        check("R1 start_flag", start_flag, 0);
        check("R1 ua_flag", ua_flag, 0);
        check("R1 bf_flag", bf_flag, 0);
        check("R1 irq_flag", irq_flag, 0);
        check("R1 ckp", ckp, 1);
        check("R1 drives", {scl_oe, sda_oe}, 0);
        check("R1 cmp_rdata", cmp_rdata, 0);
    endtask

    task automatic t_full_stretch();
        cfg_start_ie = 1'b1; cfg_stretch_en = 1'b1;
        host_write(HI_ADDR);
        bus_start();
        check("R2 start_flag", start_flag, 1);
        check("R2 irq on start", irq_flag, 1);
        pulse_irq_clr();
        send_byte(HI_ADDR, 1'b1, LO_ADDR);
        check("R3 hi ack", ack_seen, 1);
        check("R3 ua_flag", ua_flag, 1);
        check("R3 irq_flag", irq_flag, 1);
        check("R5 write ignored", cmp_rdata, HI_ADDR);
        check("R4 scl held", scl_oe, 1);
        wait_n(3 * HALF);
        check("R4 still held", scl_oe, 1);
        pulse_irq_clr();
        host_write(LO_ADDR); wait_n(1);
        check("R4 ua cleared", ua_flag, 0);
        check("R4 scl released", scl_oe, 0);
        send_byte(LO_ADDR, 1'b0, 8'h00);
        check("R6 lo ack", ack_seen, 1);
        check("R6 ua_flag", ua_flag, 1);
        check("R6 irq_flag", irq_flag, 1);
        check("R6 scl held", scl_oe, 1);
        pulse_irq_clr();
        host_write(HI_ADDR); wait_n(1);
        check("R6 scl released", scl_oe, 0);
        send_byte(8'hC3, 1'b0, 8'h00);
        check("R8 data ack", ack_seen, 1);
        check("R8 rx_data", rx_data, 8'hC3);
        check("R8 bf_flag", bf_flag, 1);
        check("R8 irq_flag", irq_flag, 1);
        check("R9 ckp cleared", ckp, 0);
        check("R9 scl held", scl_oe, 1);
        buf_rd = 1'b1; wait_n(1); buf_rd = 1'b0; wait_n(1);
        check("R10 bf cleared", bf_flag, 0);
        check("R9 hold persists", scl_oe, 1);
        ckp_set = 1'b1; wait_n(1); ckp_set = 1'b0; wait_n(1);
        check("R9 ckp set", ckp, 1);
        check("R9 scl released", scl_oe, 0);
        pulse_irq_clr();
        send_byte(8'h3C, 1'b0, 8'h00);
        check("R8 second ack", ack_seen, 1);
        check("R8 second data", rx_data, 8'h3C);
        ckp_set = 1'b1; wait_n(1); ckp_set = 1'b0; wait_n(2);
        buf_rd = 1'b1; wait_n(1); buf_rd = 1'b0;
        bus_stop();
        check("R2 stop clears start", start_flag, 0);
        pulse_irq_clr();
    endtask

    task automatic t_low_mismatch();
        cfg_start_ie = 1'b0;
        bus_start();
        check("R2 no irq without enable", irq_flag, 0);
        send_byte(HI_ADDR, 1'b0, 8'h00);
        check("R3 hi ack", ack_seen, 1);
        pulse_irq_clr();
        host_write(LO_ADDR); wait_n(1);
        send_byte(8'h5B, 1'b0, 8'h00);
        check("R7 no ack", ack_seen, 0);
        check("R7 ua_flag", ua_flag, 1);
        check("R7 irq_flag", irq_flag, 1);
        check("R7 bf_flag", bf_flag, 0);
        check("R7 ckp unchanged", ckp, 1);
        check("R7 scl free", scl_oe, 0);
        host_write(HI_ADDR); wait_n(1);
        check("R7 ua cleared by reload", ua_flag, 0);
        pulse_irq_clr();
        send_byte(8'h11, 1'b0, 8'h00);
        check("R7 later byte no ack", ack_seen, 0);
        check("R7 later byte no bf", bf_flag, 0);
        check("R7 later byte no irq", irq_flag, 0);
        bus_stop();
    endtask

    task automatic t_hi_mismatch();
        bus_start();
        send_byte(HI_ADDR | 8'h01, 1'b0, 8'h00);
        check("R11 no ack", ack_seen, 0);
        check("R11 ua_flag", ua_flag, 0);
        check("R11 irq_flag", irq_flag, 0);
        check("R11 scl free", scl_oe, 0);
        send_byte(LO_ADDR, 1'b0, 8'h00);
        check("R11 rest ignored", ack_seen, 0);
        bus_stop();
    endtask

    task automatic t_no_stretch();
        cfg_stretch_en = 1'b0;
        bus_start();
        send_byte(HI_ADDR, 1'b0, 8'h00);
        host_write(LO_ADDR); wait_n(1);
        send_byte(LO_ADDR, 1'b0, 8'h00);
        check("R6 lo ack", ack_seen, 1);
        host_write(HI_ADDR); wait_n(1);
        pulse_irq_clr();
        send_byte(8'hA5, 1'b0, 8'h00);
        check("R12 data ack", ack_seen, 1);
        check("R12 rx_data", rx_data, 8'hA5);
        check("R12 no hold", scl_oe, 0);
        check("R12 ckp kept", ckp, 1);
        check("R12 bf_flag", bf_flag, 1);
        bus_stop();
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_full_stretch();
        t_low_mismatch();
        t_hi_mismatch();
        t_no_stretch();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule